// File: doc/BRIEF.md
# Calibrated RTC Seconds Prescaler

This block turns a 32,768 Hz crystal clock into a one-pulse-per-second tick for a real-time clock. It corrects crystal frequency error digitally instead of with trim capacitors. Over a repeating 64-minute correction cycle, selected seconds are made shorter or longer by a fixed number of oscillator cycles. The adjustment is made in a two-stage divider, at the stage that divides by 256.

A 5-bit magnitude and a sign bit set the correction. A magnitude of N corrects the first 2N minutes of the cycle. In each corrected minute only the first second is adjusted. Positive correction drops one 256-cycle stage from that second. Negative correction stretches its last stage by 128 cycles.

A separate free-running divider drives a frequency-test square wave of 512 Hz, which is never touched by the correction. This lets production test measure the raw crystal error directly. The block also reports the current minute index within the correction cycle.

Top module: `calib_prescaler`

## Requirements
- R1: While reset is asserted, and right after it is released, `secTick` is 0, `minIdx` is 0 and `ftOut` is 0.
- R2: An uncorrected second lasts exactly 2^(STAGE_LOG2+STAGES_LOG2) oscillator cycles. With the default parameters this is 32,768 cycles.
- R3: With `calPos`=1 (speed up), the first second of a corrected minute lasts one stage (2^STAGE_LOG2, default 256) fewer cycles than nominal.
- R4: With `calPos`=0 (slow down), the first second of a corrected minute lasts NEG_ADJ (default 128) more cycles than nominal.
- R5: Only second 0 of a corrected minute is adjusted. Every other second of that minute has the nominal length.
- R6: Minute m is corrected if, and only if, m < 2×magnitude and m < ELIGIBLE (62). `minIdx` counts minutes 0 to 63 and then wraps to 0. A minute holds SECS_PER_MIN (default 60) seconds.
- R7: `calMag` and `calPos` are sampled once, at the start of each minute. A change made within a minute takes effect only from the next minute.
- R8: With `ftEn`=1, `ftOut` toggles every 2^FT_LOG2 cycles (default 32, giving 512 Hz). The magnitude and sign have no effect on it.
- R9: With `ftEn`=0, `ftOut` is held low, starting from the clock edge after `ftEn` falls.
- R10: `secTick` is high for exactly one oscillator cycle per second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock (nominal 32,768 Hz) |
| rstN | input | 1 | Asynchronous reset, active low |
| calMag | input | CAL_W (5) | Correction magnitude, 0 to 31 |
| calPos | input | 1 | Correction sign: 1 speeds up, 0 slows down |
| ftEn | input | 1 | Frequency-test enable |
| secTick | output | 1 | One-cycle pulse at the end of each second |
| ftOut | output | 1 | 512 Hz test square wave, low when disabled |
| minIdx | output | MIN_W (6) | Minute index within the 64-minute correction cycle |

## Verification
A corrupted divider count shows up as a wrong interval between two `secTick` pulses, within the same second. A wrong second or minute counter, or a wrongly latched correction value, shows up within one minute. In that case a correction lands on the wrong second or the wrong minute, or `minIdx` disagrees at the next tick. Test-output faults appear within two toggle periods as a wrong edge spacing. The interval of every tick is compared against a model that tracks seconds, minutes and the sampled correction values. Reduced divider parameters let several full correction cycles run.

// File: rtl/calib_pkg.sv
package calib_pkg;
  // Adjustment strobes from the control to the divider for the current second
  typedef struct packed {
    logic shortSec;  // drop one stage from this second
    logic longSec;   // stretch the final stage of this second
  } adjStrobe_t;
endpackage

// File: rtl/calib_ctrl.sv
module calib_ctrl
  import calib_pkg::*;
#(
  parameter int CAL_W         = 5,
  parameter int SECS_PER_MIN  = 60,
  parameter int MIN_PER_CYCLE = 64,
  parameter int ELIGIBLE      = 62,
  localparam int SEC_W = (SECS_PER_MIN > 1) ? $clog2(SECS_PER_MIN) : 1,
  localparam int MIN_W = $clog2(MIN_PER_CYCLE)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             secTick,
  input  logic [CAL_W-1:0] calMag,
  input  logic             calPos,
  output adjStrobe_t       strobe,
  output logic [MIN_W-1:0] minIdx
);
  logic [SEC_W-1:0] secCnt;
  logic [MIN_W-1:0] minCnt;
  logic [CAL_W-1:0] magLatch;
  logic             posLatch;
  logic             loadPend;
  logic             lastSec;
  logic             loadNow;
  logic [CAL_W:0]   twiceMag;
  logic             corrMin;

  assign lastSec  = (secCnt == SEC_W'(SECS_PER_MIN - 1));
  assign loadNow  = loadPend || (secTick && lastSec);
  assign twiceMag = {magLatch, 1'b0};
  assign corrMin  = (int'(minCnt) < int'(twiceMag)) && (int'(minCnt) < ELIGIBLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secCnt   <= '0;
      minCnt   <= '0;
      magLatch <= '0;
      posLatch <= 1'b0;
      loadPend <= 1'b1;
    end else begin
      loadPend <= 1'b0;
      if (loadNow) begin
        magLatch <= calMag;
        posLatch <= calPos;
      end
      if (secTick) begin
        if (lastSec) begin
          secCnt <= '0;
          minCnt <= (minCnt == MIN_W'(MIN_PER_CYCLE - 1)) ? '0 : minCnt + 1'b1;
        end else begin
          secCnt <= secCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.shortSec = (secCnt == '0) && corrMin && posLatch;
    strobe.longSec  = (secCnt == '0) && corrMin && !posLatch;
  end

  assign minIdx = minCnt;

  AST_SEC_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    int'(secCnt) < SECS_PER_MIN); // R6
  AST_MIN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && lastSec) |=> (secCnt == '0 &&
      int'(minCnt) == ((int'($past(minCnt)) + 1) % MIN_PER_CYCLE))); // R6
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !loadNow |=> ($stable(magLatch) && $stable(posLatch))); // R7
  AST_STROBE_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.shortSec || strobe.longSec) |-> (secCnt == '0 && int'(minCnt) < ELIGIBLE)); // R5
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobe.shortSec, strobe.longSec}) <= 1); // R3
endmodule

// File: rtl/calib_divider.sv
module calib_divider
  import calib_pkg::*;
#(
  parameter int STAGE_LOG2  = 8,
  parameter int STAGES_LOG2 = 7,
  parameter int NEG_ADJ     = 128,
  localparam int STAGE  = 1 << STAGE_LOG2,
  localparam int STAGES = 1 << STAGES_LOG2,
  localparam int LOW_W  = STAGE_LOG2 + 1,
  localparam int HIGH_W = STAGES_LOG2
) (
  input  logic       clk,
  input  logic       rstN,
  input  adjStrobe_t strobe,
  output logic       secTick
);
  logic [LOW_W-1:0]  lowCnt;
  logic [HIGH_W-1:0] highCnt;
  logic [LOW_W-1:0]  lowLimit;
  logic [HIGH_W-1:0] highLimit;
  logic              lowWrap;

  // Positive: the high stage ends one step early. Negative: last stage stretched.
  assign highLimit = strobe.shortSec ? HIGH_W'(STAGES - 2) : HIGH_W'(STAGES - 1);
  assign lowLimit  = (strobe.longSec && highCnt == highLimit)
                     ? LOW_W'(STAGE - 1 + NEG_ADJ) : LOW_W'(STAGE - 1);
  assign lowWrap   = (lowCnt == lowLimit);
  assign secTick   = lowWrap && (highCnt == highLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt  <= '0;
      highCnt <= '0;
    end else if (secTick) begin
      lowCnt  <= '0;
      highCnt <= '0;
    end else if (lowWrap) begin
      lowCnt  <= '0;
      highCnt <= highCnt + 1'b1;
    end else begin
      lowCnt  <= lowCnt + 1'b1;
    end
  end

  AST_TICK_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    secTick |=> (lowCnt == '0 && highCnt == '0 && !secTick)); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    int'(lowCnt) <= STAGE - 1 + NEG_ADJ); // R4
  AST_SHORT_END: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.shortSec && lowWrap && int'(highCnt) == STAGES - 2) |-> secTick); // R3
endmodule

// File: rtl/calib_testout.sv
module calib_testout #(
  parameter int FT_LOG2 = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic ftEn,
  output logic ftOut
);
  logic [FT_LOG2-1:0] ftCnt;
  logic               ftWrap;

  assign ftWrap = (ftCnt == '1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ftCnt <= '0;
      ftOut <= 1'b0;
    end else begin
      ftCnt <= ftCnt + 1'b1;
      ftOut <= ftEn ? (ftWrap ? !ftOut : ftOut) : 1'b0;
    end
  end

  AST_FT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !ftEn |=> !ftOut); // R9
  AST_FT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ftEn && $past(ftEn) && !ftWrap) |=> $stable(ftOut)); // R8
endmodule

// File: rtl/calib_prescaler.sv
module calib_prescaler
  import calib_pkg::*;
#(
  parameter int CAL_W         = 5,
  parameter int STAGE_LOG2    = 8,
  parameter int STAGES_LOG2   = 7,
  parameter int NEG_ADJ       = 128,
  parameter int SECS_PER_MIN  = 60,
  parameter int MIN_PER_CYCLE = 64,
  parameter int ELIGIBLE      = 62,
  parameter int FT_LOG2       = 5,
  localparam int MIN_W = $clog2(MIN_PER_CYCLE)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CAL_W-1:0] calMag,
  input  logic             calPos,
  input  logic             ftEn,
  output logic             secTick,
  output logic             ftOut,
  output logic [MIN_W-1:0] minIdx
);
  adjStrobe_t strobe;

  calib_ctrl #(
    .CAL_W(CAL_W), .SECS_PER_MIN(SECS_PER_MIN),
    .MIN_PER_CYCLE(MIN_PER_CYCLE), .ELIGIBLE(ELIGIBLE)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .secTick(secTick), .calMag(calMag),
    .calPos(calPos), .strobe(strobe), .minIdx(minIdx)
  );

  calib_divider #(
    .STAGE_LOG2(STAGE_LOG2), .STAGES_LOG2(STAGES_LOG2), .NEG_ADJ(NEG_ADJ)
  ) i_div (
    .clk(clk), .rstN(rstN), .strobe(strobe), .secTick(secTick)
  );

  calib_testout #(.FT_LOG2(FT_LOG2)) i_ft (
    .clk(clk), .rstN(rstN), .ftEn(ftEn), .ftOut(ftOut)
  );
endmodule

// File: tb/test_calib_prescaler.sv
module test_calib_prescaler;
  localparam int STAGE_LOG2  = 4;
  localparam int STAGES_LOG2 = 5;
  localparam int NEG_ADJ     = 8;
  localparam int SPM         = 2;
  localparam int MPC         = 64;
  localparam int ELIG        = 62;
  localparam int FT_LOG2     = 2;
  localparam int NOMINAL     = 1 << (STAGE_LOG2 + STAGES_LOG2);
  localparam int STAGE       = 1 << STAGE_LOG2;
  localparam int FT_HALF     = 1 << FT_LOG2;
  localparam int TICK_TARGET = 150;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] calMag = 5'd31;
  logic       calPos = 1'b1;
  logic       ftEn = 1'b0;
  logic       secTick;
  logic       ftOut;
  logic [5:0] minIdx;

  int total = 0;
  int bad = 0;
  int edgeCnt = 0;
  int lastTick = -1;
  int ticks = 0;
  int mSec = 0;
  int mMin = 0;
  int mMag = 31;
  bit mPos = 1'b1;
  bit prevTick = 1'b0;
  bit prevFt = 1'b0;
  int ftSeen = 0;
  int lastFt = 0;
  bit done = 1'b0;

  always #2 clk = !clk;

  calib_prescaler #(
    .CAL_W(5), .STAGE_LOG2(STAGE_LOG2), .STAGES_LOG2(STAGES_LOG2),
    .NEG_ADJ(NEG_ADJ), .SECS_PER_MIN(SPM), .MIN_PER_CYCLE(MPC),
    .ELIGIBLE(ELIG), .FT_LOG2(FT_LOG2)
  ) i_calib_prescaler (
    .clk(clk), .rstN(rstN), .calMag(calMag), .calPos(calPos), .ftEn(ftEn),
    .secTick(secTick), .ftOut(ftOut), .minIdx(minIdx)
  );

  function automatic int expLen(int sec, int mins, int mag, bit pos);
    if (sec == 0 && mins < 2 * mag && mins < ELIG)
      return pos ? NOMINAL - STAGE : NOMINAL + NEG_ADJ;
    return NOMINAL;
  endfunction

  function automatic string lenTag(int sec, int mins, int mag, bit pos);
    if (sec != 0) return "R5";
    if (mins < 2 * mag && mins < ELIG) return pos ? "R3" : "R4";
    return "R2/R6";
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) if (rstN) edgeCnt <= edgeCnt + 1;

  // Tick model: interval length, minute index, pulse width
  always @(negedge clk) begin
    if (rstN) begin
      if (prevTick) check(!secTick, "R10 tick width", int'(secTick), 0);
      if (secTick) begin
        int e;
        e = expLen(mSec, mMin, mMag, mPos);
        check(edgeCnt - lastTick == e, lenTag(mSec, mMin, mMag, mPos),
              edgeCnt - lastTick, e);
        check(int'(minIdx) == mMin, "R6 minIdx", int'(minIdx), mMin);
        if (mSec == SPM - 1) begin
          mSec = 0;
          mMin = (mMin + 1) % MPC;
          mMag = int'(calMag);   // R7: sampled only at minute start
          mPos = calPos;
        end else begin
          mSec++;
        end
        lastTick = edgeCnt;
        ticks++;
      end
      prevTick = secTick;
    end
  end

  // Test output spacing
  always @(negedge clk) begin
    if (rstN) begin
      if (!ftEn) ftSeen = 0;
      else if (ftOut != prevFt) begin
        if (ftSeen >= 1) check(edgeCnt - lastFt == FT_HALF, "R8 ft spacing",
                               edgeCnt - lastFt, FT_HALF);
        ftSeen++;
        lastFt = edgeCnt;
      end
      prevFt = ftOut;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(!secTick, "R1 tick in reset", int'(secTick), 0);
    check(minIdx == 6'd0, "R1 minIdx in reset", int'(minIdx), 0);
    check(!ftOut, "R1 ftOut in reset", int'(ftOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(minIdx == 6'd0 && !secTick, "R1 after release", int'(minIdx), 0);
    // R9: disabled test output stays low
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      check(!ftOut, "R9 ft disabled", int'(ftOut), 0);
    end
    @(posedge clk); #1 ftEn = 1'b1;
    // Random correction changes, made mid-second well clear of ticks
    while (ticks < TICK_TARGET) begin
      @(negedge clk);
      if (secTick) begin
        repeat (5 + int'($urandom_range(0, 80))) @(negedge clk);
        @(posedge clk); #1;
        if (ticks == 40) begin
          calMag = 5'd0;          // directed: no correction at all
        end else if (ticks == 70) begin
          calMag = 5'd31; calPos = 1'b0;  // directed: full negative range
        end else if (ticks > 100 && $urandom_range(0, 2) == 0) begin
          calMag = 5'($urandom_range(0, 31));
          calPos = 1'($urandom_range(0, 1));
        end
      end
    end
    @(posedge clk); #1 ftEn = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check(!ftOut, "R9 ft disabled again", int'(ftOut), 0);
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", ticks, TICK_TARGET);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule